// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

This block is one DMA channel that walks a list of descriptors in memory. Software first writes five channel registers directly: the link word, the byte count, the source address, the destination address and the control word. Setting the enable bit of the control word starts the node held in those registers. The channel moves the node one 32-bit beat at a time. Each beat is a read from the source, followed by a write of the same word to the destination. The source and destination pointers can each advance by four bytes per beat or stay fixed.

When a node finishes, the link word decides what comes next. If the link word allows chaining, the channel reads the next 32-byte descriptor from memory through the same read port and runs it. Otherwise the list is finished. A link that points back to an earlier node builds a ring, and the channel loops around it until software clears enable. Clearing enable pauses the channel and setting it again resumes. While the channel runs, the remaining byte count and the current link word can be read back. A per-node control bit raises a per-node event, and the end of the list raises a separate event.

Top module: `lldma_channel`

## Requirements
- R1: After a synchronous reset the outputs are quiet: `busy`, `rd_en`, `wr_en`, `node_irq` and `end_irq` are 0, and `cur_count` and `cur_link` are 0.
- R2: While idle, `reg_sel` selects the register that `reg_we` writes: 0 link, 1 count, 2 source, 3 destination, 4 control. Writing control with bit 0 set starts the loaded node. Each beat reads the source address, then writes the returned word to the destination address. After each accepted write, the source advances by 4 if control bit 31 is set and the destination advances by 4 if control bit 30 is set; otherwise each pointer stays fixed.
- R3: `cur_count` shows the remaining byte count of the node in progress. Each accepted write lowers it by 4, or to 0 when 4 or fewer bytes remain. Any count loaded above 0x1FFC is clamped to 0x1FFC.
- R4: A descriptor at base B (the link word with its low five bits cleared) is fetched as five reads in this order: B+0x00 link, B+0x10 count, B+0x14 source, B+0x18 destination, B+0x1C control. Offsets 0x04 to 0x0C are never read. No fetch read starts before the last data write of the previous node has been accepted, and a read and a write are never requested together.
- R5: When a node ends and link bit 1 is clear (a zero link included), the list ends. `busy` falls, `end_irq` pulses for one cycle, and control bit 0 is cleared. When link bit 1 is set, the next descriptor is fetched.
- R6: At the end of each node whose control bit 1 is set, `node_irq` pulses for one cycle. A node with that bit clear gives no pulse.
- R7: A node with a zero count makes no data access and goes straight to its link decision.
- R8: A link that points back into the list makes the channel loop without end. `busy` stays high until software intervenes.
- R9: While busy, a write to the control register changes only its enable bit, and writes to other registers are ignored. With enable clear, no new memory request is issued and the count and pointers hold. A request already issued still completes. Setting enable again continues without losing or repeating a beat.
- R10: `cur_link` shows the link word of the node in progress, which is the address of the next node once that node's descriptor has been fetched.
- R11: If a software write to control lands in the same cycle as the fetched control word is accepted, the enable bit from software wins and the other fields come from memory.
- R12: Once raised, `rd_en` holds with a stable address until `rd_valid`. Once raised, `wr_en` holds with stable address and data until `wr_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 link, 1 count, 2 source, 3 destination, 4 control) |
| reg_wdata | input | 32 | Register write data |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_valid | input | 1 | Read data returned, accepts the request |
| rd_data | input | 32 | Read data |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ready | input | 1 | Write accepted |
| cur_count | output | 16 | Remaining bytes of the node in progress |
| cur_link | output | 32 | Link word of the node in progress |
| busy | output | 1 | Channel active |
| node_irq | output | 1 | One-cycle per-node event |
| end_irq | output | 1 | One-cycle end-of-list event |

## Verification
Two things can happen in the same cycle: the fetch of a descriptor's control word can complete just as software writes the control register to pause. The bench runs a ring with zero read latency and watches for the request at offset 0x1C. At the falling edge before that read is accepted, it drives a control write that clears enable, so both updates land on one rising edge. The expected result is a paused channel: busy stays high, the freshly loaded count of 8 shows on `cur_count`, and no later memory request appears until enable is set again.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_RD    = 3'd2,
    S_WR    = 3'd3,
    S_NODE  = 3'd4
  } seq_state_e;

  localparam logic [2:0] SEL_LINK  = 3'd0;
  localparam logic [2:0] SEL_COUNT = 3'd1;
  localparam logic [2:0] SEL_SRC   = 3'd2;
  localparam logic [2:0] SEL_DST   = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_NIRQ_BIT  = 1;
  localparam int CTRL_SINC_BIT  = 31;
  localparam int CTRL_DINC_BIT  = 30;
  localparam int LINK_CHAIN_BIT = 1;

  localparam int DESC_ALIGN_BITS = 5;
  localparam int DESC_READS      = 5;

  // Byte offset inside a descriptor of fetch step idx (link, count, src, dst, ctrl).
  function automatic logic [DESC_ALIGN_BITS-1:0] fetch_off(input logic [2:0] idx);
    if (idx == 3'd0) fetch_off = '0;
    else             fetch_off = 5'h0C + {idx[2:0], 2'b00};
  endfunction

endpackage

// File: rtl/lldma_addr_reg.sv
module lldma_addr_reg #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step,
  input  logic          inc,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk) begin
    if (rst)              addr <= '0;
    else if (ld)          addr <= ld_val;
    else if (step && inc) addr <= addr + STEP_V;
  end
endmodule

// File: rtl/lldma_count_reg.sv
module lldma_count_reg #(
  parameter int CW       = 16,
  parameter int MAX_NODE = 32'h1FFC,
  parameter int BEAT     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [31:0]   ld_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          zero
);
  localparam logic [CW-1:0] MAX_V  = CW'(MAX_NODE);
  localparam logic [CW-1:0] BEAT_V = CW'(BEAT);

  logic [CW-1:0] ld_clamped;
  assign ld_clamped = (ld_val > 32'(MAX_NODE)) ? MAX_V : ld_val[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_clamped;
    else if (dec) cnt <= (cnt > BEAT_V) ? (cnt - BEAT_V) : '0;
  end

  assign last = (cnt <= BEAT_V);
  assign zero = (cnt == '0);

  assert_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt <= MAX_V));
endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int CW       = 16,
  parameter int MAX_NODE = 32'h1FFC,
  parameter int BEAT     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  input  logic          wr_ready,
  output logic [CW-1:0] cur_count,
  output logic [31:0]   cur_link,
  output logic          busy,
  output logic          node_irq,
  output logic          end_irq
);
  localparam int NPTR = 2;   // 0 = source, 1 = destination

  seq_state_e    st_q;
  logic [2:0]    fidx_q;
  logic [31:0]   link_q, ctrl_q, data_q;
  logic [AW-1:0] base_q;
  logic          rd_en_q, wr_en_q, node_irq_q, end_irq_q;
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [31:0]   wr_data_q;

  logic idle, en, fetch_acc, beat_done, chain_go, end_now;
  logic sw_link, sw_cnt, sw_ctrl, sw_ptr_src, sw_ptr_dst;
  logic cnt_ld, cnt_last, cnt_zero;
  logic [31:0]   cnt_ld_val;
  logic [CW-1:0] cnt_q;
  logic [NPTR-1:0] ptr_ld, ptr_inc;
  logic [AW-1:0]   ptr_val [NPTR];
  logic [AW-1:0]   ptr_q   [NPTR];

  assign idle      = (st_q == S_IDLE);
  assign en        = ctrl_q[CTRL_EN_BIT];
  assign fetch_acc = (st_q == S_FETCH) && rd_en_q && rd_valid;
  assign beat_done = (st_q == S_WR) && wr_en_q && wr_ready;
  assign chain_go  = link_q[LINK_CHAIN_BIT];
  assign end_now   = (st_q == S_NODE) && !chain_go;

  assign sw_link    = idle && reg_we && (reg_sel == SEL_LINK);
  assign sw_cnt     = idle && reg_we && (reg_sel == SEL_COUNT);
  assign sw_ptr_src = idle && reg_we && (reg_sel == SEL_SRC);
  assign sw_ptr_dst = idle && reg_we && (reg_sel == SEL_DST);
  assign sw_ctrl    = reg_we && (reg_sel == SEL_CTRL);

  // Count register: loaded by software when idle or by fetch step 1.
  assign cnt_ld     = sw_cnt || (fetch_acc && fidx_q == 3'd1);
  assign cnt_ld_val = idle ? reg_wdata : rd_data;

  lldma_count_reg #(.CW(CW), .MAX_NODE(MAX_NODE), .BEAT(BEAT)) u_count (
    .clk(clk), .rst(rst), .ld(cnt_ld), .ld_val(cnt_ld_val), .dec(beat_done),
    .cnt(cnt_q), .last(cnt_last), .zero(cnt_zero)
  );

  // Source and destination pointers share one structure.
  assign ptr_ld[0]  = sw_ptr_src || (fetch_acc && fidx_q == 3'd2);
  assign ptr_ld[1]  = sw_ptr_dst || (fetch_acc && fidx_q == 3'd3);
  assign ptr_inc[0] = ctrl_q[CTRL_SINC_BIT];
  assign ptr_inc[1] = ctrl_q[CTRL_DINC_BIT];

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    assign ptr_val[g] = idle ? AW'(reg_wdata) : AW'(rd_data);
    lldma_addr_reg #(.AW(AW), .STEP(BEAT)) u_ptr (
      .clk(clk), .rst(rst), .ld(ptr_ld[g]), .ld_val(ptr_val[g]),
      .step(beat_done), .inc(ptr_inc[g]), .addr(ptr_q[g])
    );
  end

  // Link word.
  always_ff @(posedge clk) begin
    if (rst)                                link_q <= '0;
    else if (sw_link)                       link_q <= reg_wdata;
    else if (fetch_acc && fidx_q == 3'd0)   link_q <= rd_data;
  end

  // Control word: later assignments take priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (fetch_acc && fidx_q == 3'd4) ctrl_q <= rd_data;
      if (sw_ctrl && idle)             ctrl_q <= reg_wdata;
      if (sw_ctrl && !idle)            ctrl_q[CTRL_EN_BIT] <= reg_wdata[CTRL_EN_BIT];
      if (end_now)                     ctrl_q[CTRL_EN_BIT] <= 1'b0;
    end
  end

  // Sequencer.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      fidx_q     <= '0;
      base_q     <= '0;
      data_q     <= '0;
      rd_en_q    <= 1'b0;
      rd_addr_q  <= '0;
      wr_en_q    <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      node_irq_q <= 1'b0;
      end_irq_q  <= 1'b0;
    end else begin
      node_irq_q <= 1'b0;
      end_irq_q  <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (sw_ctrl && reg_wdata[CTRL_EN_BIT]) st_q <= S_RD;
        end
        S_FETCH: begin
          if (!rd_en_q) begin
            if (en) begin
              rd_en_q   <= 1'b1;
              rd_addr_q <= base_q | {{(AW-DESC_ALIGN_BITS){1'b0}}, fetch_off(fidx_q)};
            end
          end else if (rd_valid) begin
            rd_en_q <= 1'b0;
            if (fidx_q == 3'(DESC_READS - 1)) begin
              fidx_q <= '0;
              st_q   <= S_RD;
            end else begin
              fidx_q <= fidx_q + 3'd1;
            end
          end
        end
        S_RD: begin
          if (!rd_en_q) begin
            if (en) begin
              if (cnt_zero) begin
                st_q <= S_NODE;
              end else begin
                rd_en_q   <= 1'b1;
                rd_addr_q <= ptr_q[0];
              end
            end
          end else if (rd_valid) begin
            rd_en_q <= 1'b0;
            data_q  <= rd_data;
            st_q    <= S_WR;
          end
        end
        S_WR: begin
          if (!wr_en_q) begin
            if (en) begin
              wr_en_q   <= 1'b1;
              wr_addr_q <= ptr_q[1];
              wr_data_q <= data_q;
            end
          end else if (wr_ready) begin
            wr_en_q <= 1'b0;
            st_q    <= cnt_last ? S_NODE : S_RD;
          end
        end
        S_NODE: begin
          node_irq_q <= ctrl_q[CTRL_NIRQ_BIT];
          if (chain_go) begin
            st_q   <= S_FETCH;
            fidx_q <= '0;
            base_q <= {link_q[AW-1:DESC_ALIGN_BITS], {DESC_ALIGN_BITS{1'b0}}};
          end else begin
            st_q      <= S_IDLE;
            end_irq_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rd_en     = rd_en_q;
  assign rd_addr   = rd_addr_q;
  assign wr_en     = wr_en_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = wr_data_q;
  assign cur_count = cnt_q;
  assign cur_link  = link_q;
  assign busy      = !idle;
  assign node_irq  = node_irq_q;
  assign end_irq   = end_irq_q;

  logic unused_bits;
  assign unused_bits = ^{ctrl_q[29:2], link_q[4:2], link_q[0]};

  // ---------------- assertions ----------------
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_en && !wr_en));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_valid) |=> (rd_en && $stable(rd_addr)));

  assert_wr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ready) |=> (wr_en && $stable(wr_addr) && $stable(wr_data)));

  assert_no_rd_wr_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ready) |=>
      (cur_count == (($past(cur_count) > CW'(BEAT)) ? ($past(cur_count) - CW'(BEAT)) : '0)));

  assert_end_idle_R5: assert property (@(posedge clk) disable iff (rst)
    end_irq |-> !busy);

  assert_pause_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!en && !rd_en && !wr_en) |=> (!rd_en && !wr_en));

  assert_fetch_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_ready && cnt_last) |=> !rd_en);
endmodule

// File: tb/tb_lldma_channel.sv
module tb_lldma_channel;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, reg_we;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic        rd_en, rd_valid, wr_en, wr_ready;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data, cur_link;
  logic [15:0] cur_count;
  logic        busy, node_irq, end_irq;

  lldma_channel dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .cur_count(cur_count), .cur_link(cur_link), .busy(busy),
    .node_irq(node_irq), .end_irq(end_irq)
  );

  logic [31:0] mem [0:1023];
  int rd_lat = 0, wr_lat = 0, rwait = 0, wwait = 0;
  int n_node = 0, n_end = 0, ev_n = 0;
  logic        ev_w [0:4095];
  logic [31:0] ev_a [0:4095];
  logic [31:0] ev_d [0:4095];
  logic [15:0] ev_c [0:4095];
  int checks = 0, fails = 0;

  logic        xw [0:255];
  logic [31:0] xa [0:255];
  logic [31:0] xd [0:255];
  logic [15:0] xc [0:255];
  int xn;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hA500_0000 | {16'h0, a[15:0]};
  endfunction

  // Memory model: decides handshakes at the falling edge, logs accepted transfers.
  initial begin
    rd_valid = 1'b0; rd_data = '0; wr_ready = 1'b0;
  end
  always @(negedge clk) begin
    bit rv, wv;
    if (node_irq) n_node = n_node + 1;
    if (end_irq)  n_end  = n_end + 1;
    rv = 1'b0; wv = 1'b0;
    if (rd_en) begin rv = (rwait >= rd_lat); rwait = rv ? 0 : rwait + 1; end
    else rwait = 0;
    if (wr_en) begin wv = (wwait >= wr_lat); wwait = wv ? 0 : wwait + 1; end
    else wwait = 0;
    rd_valid = rv;
    rd_data  = mem[rd_addr[11:2]];
    wr_ready = wv;
    if (rv && ev_n < 4096) begin
      ev_w[ev_n] = 1'b0; ev_a[ev_n] = rd_addr; ev_d[ev_n] = '0; ev_c[ev_n] = cur_count;
      ev_n = ev_n + 1;
    end
    if (wv && ev_n < 4096) begin
      ev_w[ev_n] = 1'b1; ev_a[ev_n] = wr_addr; ev_d[ev_n] = wr_data; ev_c[ev_n] = cur_count;
      ev_n = ev_n + 1;
    end
  end

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic prog(input logic [31:0] l, c, s, d, k);
    wreg(3'd0, l); wreg(3'd1, c); wreg(3'd2, s); wreg(3'd3, d); wreg(3'd4, k);
  endtask

  task automatic put_desc(input logic [31:0] b, l, c, s, d, k);
    mem[b[11:2]]     = l;
    mem[b[11:2] + 1] = 32'hDEAD_BEEF;
    mem[b[11:2] + 2] = 32'hDEAD_BEEF;
    mem[b[11:2] + 3] = 32'hDEAD_BEEF;
    mem[b[11:2] + 4] = c;
    mem[b[11:2] + 5] = s;
    mem[b[11:2] + 6] = d;
    mem[b[11:2] + 7] = k;
  endtask

  task automatic push(input logic w, input logic [31:0] a, d, input logic [15:0] c);
    xw[xn] = w; xa[xn] = a; xd[xn] = d; xc[xn] = c; xn++;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(negedge clk);
  endtask

  task automatic wait_nodes(input int target);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (n_node >= target) break;
    end
  endtask

  task automatic compare_log(input int base, input string tag);
    chk_eq($sformatf("%s event count", tag), ev_n - base, xn);
    for (int k = 0; k < xn; k++) begin
      if (base + k < ev_n) begin
        chk_eq($sformatf("%s ev%0d kind", tag, k), ev_w[base+k], xw[k]);
        chk_eq($sformatf("%s ev%0d addr", tag, k), ev_a[base+k], xa[k]);
        if (xw[k]) begin
          chk_eq($sformatf("R2 ev%0d data", k), ev_d[base+k], xd[k]);
          chk_eq($sformatf("R3 ev%0d remaining", k), ev_c[base+k], xc[k]);
        end
      end
    end
  endtask

  task automatic run_single(input int cnt, input int mode);
    int base, nn, ne, n;
    logic si, di, ni;
    logic [31:0] k32;
    si = mode[0]; di = mode[1]; ni = cnt[0];
    rd_lat = cnt % 3; wr_lat = (cnt + mode) % 2;
    base = ev_n; nn = n_node; ne = n_end; xn = 0;
    n = (cnt + 3) / 4;
    for (int k = 0; k < n; k++) begin
      k32 = 32'(4 * k);
      push(1'b0, 32'h100 + (si ? k32 : 0), 0, 0);
      push(1'b1, 32'h800 + (di ? k32 : 0), pat(32'h100 + (si ? k32 : 0)), 16'(cnt - 4 * k));
    end
    prog(32'h0, 32'(cnt), 32'h100, 32'h800, {si, di, 28'h0, ni, 1'b1});
    wait_idle();
    compare_log(base, "R2");
    if (cnt == 0) chk_eq("R7 zero count makes no access", ev_n - base, 0);
    chk_eq("R5 end pulse count", n_end - ne, 1);
    chk_eq("R6 node pulse count", n_node - nn, {31'h0, ni});
    chk_eq("R5 busy after end", {31'h0, busy}, 0);
    chk_eq("R3 count after end", {16'h0, cur_count}, 0);
  endtask

  task automatic run_chain(input logic [31:0] endlink);
    int base, nn, ne;
    rd_lat = 1; wr_lat = 0;
    put_desc(32'h400, 32'h422, 0, 32'h140, 32'h840, 32'hC000_0003);
    put_desc(32'h420, endlink, 12, 32'h180, 32'h880, 32'h8000_0003);
    put_desc(32'h440, 32'h0, 4, 32'h1C0, 32'h8C0, 32'hC000_0003);
    base = ev_n; nn = n_node; ne = n_end; xn = 0;
    push(0, 32'h100, 0, 0); push(1, 32'h800, pat(32'h100), 8);
    push(0, 32'h104, 0, 0); push(1, 32'h804, pat(32'h104), 4);
    push(0, 32'h400, 0, 0); push(0, 32'h410, 0, 0); push(0, 32'h414, 0, 0);
    push(0, 32'h418, 0, 0); push(0, 32'h41C, 0, 0);
    push(0, 32'h420, 0, 0); push(0, 32'h430, 0, 0); push(0, 32'h434, 0, 0);
    push(0, 32'h438, 0, 0); push(0, 32'h43C, 0, 0);
    push(0, 32'h180, 0, 0); push(1, 32'h880, pat(32'h180), 12);
    push(0, 32'h184, 0, 0); push(1, 32'h880, pat(32'h184), 8);
    push(0, 32'h188, 0, 0); push(1, 32'h880, pat(32'h188), 4);
    prog(32'h402, 8, 32'h100, 32'h800, 32'hC000_0001);
    wait_idle();
    compare_log(base, "R4 chain/R7");
    chk_eq("R6 node pulses in chain", n_node - nn, 2);
    chk_eq("R5 end pulse in chain", n_end - ne, 1);
    chk_eq("R10 link of last node", cur_link, endlink);
    chk_eq("R5 busy after chain", {31'h0, busy}, 0);
  endtask

  task automatic run_ring();
    int base, e0, e1, j;
    logic [15:0] c0;
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    rd_lat = 1; wr_lat = 1;
    put_desc(32'h480, 32'h482, 8, 32'h200, 32'h900, 32'hC000_0003);
    base = ev_n;
    prog(32'h482, 8, 32'h200, 32'h900, 32'hC000_0003);
    wait_nodes(n_node + 4);
    chk_eq("R8 ring still busy", {31'h0, busy}, 1);
    chk_eq("R10 ring link", cur_link, 32'h482);
    wreg(3'd4, 32'h0);
    repeat (10) @(negedge clk);
    e0 = ev_n; c0 = cur_count;
    wreg(3'd2, 32'h300);
    repeat (40) @(negedge clk);
    chk_eq("R9 no transfer while paused", ev_n, e0);
    chk_eq("R9 count held while paused", {16'h0, cur_count}, {16'h0, c0});
    chk_eq("R9 busy while paused", {31'h0, busy}, 1);
    wreg(3'd4, 32'h1);
    wait_nodes(n_node + 3);
    rd_lat = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (rd_en && rd_addr == 32'h49C) begin
        reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 32'h0;
        @(negedge clk);
        reg_we = 1'b0;
        break;
      end
    end
    repeat (5) @(negedge clk);
    e1 = ev_n;
    repeat (30) @(negedge clk);
    chk_eq("R11 last access is control fetch", ev_a[e1-1], 32'h49C);
    chk_eq("R11 no access after same-cycle pause", ev_n, e1);
    chk_eq("R11 new count visible", {16'h0, cur_count}, 8);
    chk_eq("R11 busy while paused", {31'h0, busy}, 1);
    wreg(3'd4, 32'h1);
    wait_nodes(n_node + 2);
    wreg(3'd4, 32'h0);
    repeat (10) @(negedge clk);
    j = 0;
    for (int k = base; k < ev_n; k++) begin
      if (ev_w[k]) begin
        chk_eq($sformatf("R9 ring write %0d addr", j), ev_a[k], 32'h900 + 32'(4 * (j % 2)));
        chk_eq($sformatf("R9 ring write %0d data", j), ev_d[k], pat(32'h200 + 32'(4 * (j % 2))));
        j++;
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(32'(i * 4));
    rst = 1'b1; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 busy", {31'h0, busy}, 0);
    chk_eq("R1 rd_en", {31'h0, rd_en}, 0);
    chk_eq("R1 wr_en", {31'h0, wr_en}, 0);
    chk_eq("R1 count", {16'h0, cur_count}, 0);
    chk_eq("R1 link", cur_link, 0);
    chk_eq("R1 events", {30'h0, node_irq, end_irq}, 0);
    wreg(3'd1, 32'hFFFF);
    chk_eq("R3 clamp above max", {16'h0, cur_count}, 32'h1FFC);
    wreg(3'd1, 32'h1FFD);
    chk_eq("R3 clamp just above max", {16'h0, cur_count}, 32'h1FFC);
    wreg(3'd1, 32'h1FFC);
    chk_eq("R3 max kept", {16'h0, cur_count}, 32'h1FFC);
    for (int c = 0; c <= 20; c++)
      for (int m = 0; m < 4; m++)
        run_single(c, m);
    run_chain(32'h440);
    run_chain(32'h0);
    run_ring();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule